// File: doc/BRIEF.md
# Panel Power Sequencer

This block switches a flat panel's three enables on and off in a fixed order. The enables are the logic supply, the data and signal drive, and the backlight. A single request level selects the direction. While the request is high the block steps toward all enables on. While it is low the block steps toward all enables off. It changes one enable per step.

A programmable wait comes before every step. A 3-bit delay setting N gives a wait of N frame periods, counted from frame-start pulses rather than from absolute time. A setting of zero shortens the wait to one dot clock. The delay is read each time a wait begins.

If the request flips during a wait, the wait runs to its end. The block then steps toward the new target from wherever it stands. A combinational busy output shows whether the enables still differ from what the request asks for.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset all three enables are low and busy is low while the request is low.
- R2: With the request high, the enables turn on one per step in the order logic, then signal, then backlight. Seen as {en_backlight, en_signal, en_logic` }` this is 001, 011, 111.
- R3: With the request low, the enables turn off in the reverse order: 011, 001, 000.
- R4: A wait begins at the clock edge where the request is first seen differing from the enables, and again at each step that does not yet reach the target. For N = 1..7, the step happens on the edge that samples the Nth frame_start pulse after that starting edge. A pulse sampled on the starting edge itself is not counted.
- R5: With N = 0, each step happens one clock after its wait starts, so successive steps fall on consecutive clock edges.
- R6: The delay setting is captured at the start of each wait. A change made during a wait affects only the following wait.
- R7: When the request flips during a wait, that wait still completes. The step it ends with goes toward the new target, and sequencing continues in that direction.
- R8: busy is high in every cycle where the enables differ from the pattern the present request asks for (111 when high, 000 when low), and low otherwise. It follows a change of the request within the same cycle.
- R9: en_backlight is never high without en_signal, en_signal is never high without en_logic, and at most one enable changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| delay_sel | input | 3 | Wait setting: 0 gives one clock, 1..7 give that many frames |
| pwr_req | input | 1 | 1 requests the panel on, 0 requests it off |
| en_logic | output | 1 | Panel logic supply enable |
| en_signal | output | 1 | Panel data and signal enable |
| en_backlight | output | 1 | Backlight enable |
| busy | output | 1 | Enables do not yet match the request |

## Verification
Full power-up and power-down runs are driven with delay settings of zero, one and three. These separate single-clock spacing from frame-counted spacing, and show whether a pulse on the starting edge is wrongly counted. One run changes the delay during the first wait, which tells capture-at-start apart from continuous sampling. Two runs flip the request right after the first step, once from off and once from on. They show whether the open wait is honoured and whether the following step goes the new way.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int NUM_RAILS = 3;
  localparam int DLY_W     = 3;
  localparam int LVL_W     = $clog2(NUM_RAILS + 1);

  typedef logic [LVL_W-1:0]     level_t;
  typedef logic [DLY_W-1:0]     dly_t;
  typedef logic [NUM_RAILS-1:0] rails_t;

  // one step from cur toward tgt, or stay if equal
  function automatic level_t step_toward(level_t cur, level_t tgt);
    if (cur < tgt)      return cur + level_t'(1);
    else if (cur > tgt) return cur - level_t'(1);
    else                return cur;
  endfunction

  // wait ends when nothing is left, or on the pulse that uses the last frame
  function automatic logic wait_done(dly_t remaining, logic pulse);
    return (remaining == '0) || (pulse && remaining == dly_t'(1));
  endfunction

  // target level for a request: every rail on, or none
  function automatic level_t target_level(logic req);
    return req ? level_t'(NUM_RAILS) : '0;
  endfunction
endpackage

// File: rtl/pps_wait_timer.sv
module pps_wait_timer
  import pps_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic frame_start,
  input  dly_t delay_sel,
  output logic active,
  output logic expire
);
  dly_t remaining;

  assign expire = active && wait_done(remaining, frame_start);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      remaining <= '0;
    end else if (load) begin
      active    <= 1'b1;
      remaining <= delay_sel;
    end else if (expire) begin
      active    <= 1'b0;
    end else if (active && frame_start && remaining != '0) begin
      remaining <= remaining - dly_t'(1);
    end
  end
endmodule

// File: rtl/pps_stage_ctrl.sv
module pps_stage_ctrl
  import pps_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_req,
  input  logic   waiting,
  input  logic   expire,
  output logic   load,
  output level_t level,
  output logic   busy
);
  level_t target;
  level_t next_level;

  always_comb begin
    target     = target_level(pwr_req);
    next_level = expire ? step_toward(level, target) : level;
    load       = (!waiting && level != target) || (expire && next_level != target);
    busy       = (level != target);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else        level <= next_level;
  end
endmodule

// File: rtl/pps_rail_decode.sv
module pps_rail_decode
  import pps_pkg::*;
(
  input  level_t level,
  output rails_t rails
);
  for (genvar i = 0; i < NUM_RAILS; i++) begin : g_rail
    assign rails[i] = (level > level_t'(i));
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [2:0] delay_sel,
  input  logic       pwr_req,
  output logic       en_logic,
  output logic       en_signal,
  output logic       en_backlight,
  output logic       busy
);
  logic   wait_start;
  logic   edge_fire;
  logic   waiting;
  level_t level;
  rails_t rails;

  pps_wait_timer u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (wait_start),
    .frame_start (frame_start),
    .delay_sel   (delay_sel),
    .active      (waiting),
    .expire      (edge_fire)
  );

  pps_stage_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_req (pwr_req),
    .waiting (waiting),
    .expire  (edge_fire),
    .load    (wait_start),
    .level   (level),
    .busy    (busy)
  );

  pps_rail_decode u_dec (
    .level (level),
    .rails (rails)
  );

  assign en_logic     = rails[0];
  assign en_signal    = rails[1];
  assign en_backlight = rails[2];
endmodule

// File: rtl/pps_chk.sv
module pps_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic [2:0] delay_sel,
  input logic       pwr_req,
  input logic       en_logic,
  input logic       en_signal,
  input logic       en_backlight,
  input logic       busy,
  input logic       wait_start,
  input logic       edge_fire,
  input logic       waiting
);
  logic [2:0] rails;
  assign rails = {en_backlight, en_signal, en_logic};

  // R9
  rail_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_backlight || en_signal) && (!en_signal || en_logic));

  // R9
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rails ^ $past(rails)) <= 1);

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_fire |=> $stable(rails));

  // R4
  frame_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_fire && !frame_start) |-> ($past(wait_start) && $past(delay_sel) == 3'd0));

  // R5
  zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_start && delay_sel == 3'd0) |=> edge_fire);

  // R7
  wait_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !edge_fire) |=> waiting);

  // R8
  idle_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rails == (pwr_req ? 3'b111 : 3'b000)));
endmodule

bind panel_pwr_seq pps_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_start  (frame_start),
  .delay_sel    (delay_sel),
  .pwr_req      (pwr_req),
  .en_logic     (en_logic),
  .en_signal    (en_signal),
  .en_backlight (en_backlight),
  .busy         (busy),
  .wait_start   (wait_start),
  .edge_fire    (edge_fire),
  .waiting      (waiting)
);

// File: tb/test_panel_pwr_seq.sv
`timescale 1ns/1ps
module test_panel_pwr_seq;
  localparam int FP = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_start = 1'b0;
  logic [2:0] delay_sel = 3'd0;
  logic       pwr_req = 1'b0;
  logic       en_logic, en_signal, en_backlight, busy;

  int checks = 0;
  int fails  = 0;
  int ecnt   = 0;
  int wd     = 0;
  int exp_vec[$];
  int exp_edge[$];
  logic [2:0] prev_vec = 3'b000;

  panel_pwr_seq i_panel_pwr_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .delay_sel(delay_sel),
    .pwr_req(pwr_req), .en_logic(en_logic), .en_signal(en_signal),
    .en_backlight(en_backlight), .busy(busy)
  );

  always #4 clk = ~clk;

  always @(posedge clk) ecnt++;

  always @(negedge clk) frame_start = (((ecnt + 1) % FP) == 0);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: every change of the enables is popped and compared
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] v;
      v = {en_backlight, en_signal, en_logic};
      if (v != prev_vec) begin
        if (exp_vec.size() == 0) begin
          check("R9 unexpected enable change", int'(v), int'(prev_vec));
        end else begin
          int ev, ee;
          ev = exp_vec.pop_front();
          ee = exp_edge.pop_front();
          check("R2/R3 enable pattern", int'(v), ev);
          check("R4/R5/R6/R7 edge timing", ecnt, ee);
        end
        prev_vec = v;
      end
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", wd);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // edge at which a wait begun on edge s with setting n ends
  function automatic int edge_after(int s, int n);
    if (n == 0) return s + 1;
    return ((s / FP) + 1) * FP + (n - 1) * FP;
  endfunction

  task automatic drain(string req, int want_vec);
    while (exp_vec.size() != 0) @(negedge clk);
    @(negedge clk);
    #1;
    check({req, " R8 busy low when done"}, int'(busy), 0);
    check({req, " final enables"}, int'({en_backlight, en_signal, en_logic}), want_vec);
  endtask

  // full sequence; delay switches to n2 one clock after the request
  task automatic run_seq(logic req, int n, int n2, string req_tag);
    int c, e1, e2, e3;
    @(negedge clk);
    delay_sel = 3'(n);
    pwr_req   = req;
    c  = ecnt + 1;
    e1 = edge_after(c, n);
    e2 = edge_after(e1, n2);
    e3 = edge_after(e2, n2);
    if (req) begin
      exp_vec.push_back(3'b001); exp_vec.push_back(3'b011); exp_vec.push_back(3'b111);
    end else begin
      exp_vec.push_back(3'b011); exp_vec.push_back(3'b001); exp_vec.push_back(3'b000);
    end
    exp_edge.push_back(e1); exp_edge.push_back(e2); exp_edge.push_back(e3);
    #1;
    check({req_tag, " R8 busy on request change"}, int'(busy), 1);
    @(negedge clk);
    delay_sel = 3'(n2);
    drain(req_tag, req ? 3'b111 : 3'b000);
  endtask

  // request flipped back right after the first step (R7)
  task automatic run_rev(logic req, int n, int start_vec, int mid_vec);
    int c, e1, e2;
    @(negedge clk);
    delay_sel = 3'(n);
    pwr_req   = req;
    c  = ecnt + 1;
    e1 = edge_after(c, n);
    e2 = edge_after(e1, n);
    exp_vec.push_back(mid_vec);   exp_edge.push_back(e1);
    exp_vec.push_back(start_vec); exp_edge.push_back(e2);
    while (ecnt < e1) @(negedge clk);
    pwr_req = ~req;
    #1;
    check("R7 busy after flip mid-sequence", int'(busy), 1);
    drain("R7", start_vec);
  endtask

  initial begin
    #1;
    check("R1 enables in reset", int'({en_backlight, en_signal, en_logic}), 0);
    check("R1 busy in reset", int'(busy), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 enables after reset", int'({en_backlight, en_signal, en_logic}), 0);
    check("R1 busy after reset", int'(busy), 0);

    run_seq(1'b1, 0, 0, "R2 R5 up zero");
    run_seq(1'b0, 0, 0, "R3 R5 down zero");
    run_seq(1'b1, 3, 3, "R2 R4 up three");
    run_seq(1'b0, 1, 1, "R3 R4 down one");
    run_seq(1'b1, 2, 1, "R6 up delay change");
    run_rev(1'b0, 2, 3'b111, 3'b011);
    run_seq(1'b0, 0, 0, "R3 down before reversal");
    run_rev(1'b1, 2, 3'b000, 3'b001);

    check("R9 no leftover expected changes", exp_vec.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule